// File: doc/BRIEF.md
# Telephony Backplane Clock and Frame Generator

This block derives the bit clocks and framing pulses for a time-division telephony backplane from one fast reference clock. It assumes a 32.768 MHz reference, so one frame of `FRAME_CYC` = 4096 reference cycles lasts 125 µs. A free-running frame counter is the single time base. Every generated clock starts its high half on the first reference cycle of each frame, so all clocks stay phase-aligned to the frame start.

Three groups of outputs are produced:
- **Primary pair.** An 8 MHz-class bit clock and an active-low frame pulse.
- **Secondary pair.** An identical clock and frame pulse, with its own enable.
- **Compatibility group.** A bit clock at a selectable rate, a companion clock at twice that rate, and a framing pulse. The framing pulse has a programmable polarity, placement and width.

Each group has an output-enable signal that goes to the pad drivers.

Software writes one 12-bit control word. Settings that are written are staged and take effect together on the first cycle of the next frame, which keeps runt pulses off the backplane. A reserved code in any 2-bit field is refused: that field keeps its previous value and a sticky error flag is raised. All other fields of the same word are accepted.

Top module: `tbus_clk_gen`

## Requirements
- R1: The control word fields are as follows. Bit 0 enables the primary pair, bit 1 the secondary pair and bit 2 the compatibility group. Bit 3 is the framing pulse polarity. Bits 5:4 are the pulse placement and bits 7:6 the pulse width. Bit 8 inverts the bit clock and bit 9 inverts the double-rate clock. Bits 11:10 are the bit clock rate. The word is written with `cfg_we_i`.
- R2: While reset is held, the outputs are: all enables 0, all clocks 0, both pair frame pulses 1, `fr_comp_o` 1 and `cfg_err_o` 0. The first rising edge after reset is released presents frame position 0.
- R3: At frame position p (0..FRAME_CYC-1), each pair clock is high when floor(p/2) is even, giving a period of 4 reference cycles. Each pair frame pulse is low for p >= FRAME_CYC-2 or p < 2.
- R4: The rate field sets the bit clock half-period: code 0 gives 8 cycles (2 MHz), code 1 gives 4 cycles (4 MHz) and code 2 gives 2 cycles (8 MHz). The bit clock is high when floor(p/half) is even.
- R5: The double-rate clock has half the bit clock's half-period and also starts high at p = 0.
- R6: When the bit-clock invert bit or the double-rate invert bit is 1, the corresponding clock is inverted.
- R7: The framing pulse is driven to the polarity bit while active and to its complement otherwise. Polarity 0 means active low.
- R8: The width field sets the pulse length W: code 0 gives 16 cycles, code 1 gives 8 cycles and code 2 gives 4 cycles.
- R9: The placement field positions the pulse. Code 0 straddles the boundary (active for p >= FRAME_CYC-W/2 or p < W/2). Code 1 covers the last bit (active for p >= FRAME_CYC-W). Code 2 covers the first bit (active for p < W).
- R10: A write that carries code 3 in the rate, width or placement field leaves that field unchanged. The other fields are still accepted. The write sets `cfg_err_o` from the next cycle, and the flag stays set until reset.
- R11: Each enable output follows its enable bit in the applied settings.
- R12: A write becomes the applied setting at frame position 0 of the next frame. Outputs for the rest of the current frame follow the earlier settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 12 | Control word |
| cfg_err_o | output | 1 | Sticky reserved-code error |
| c8_a_o | output | 1 | Primary bit clock |
| frame_a_o | output | 1 | Primary frame pulse, active low |
| oe_a_o | output | 1 | Primary pair pad enable |
| c8_b_o | output | 1 | Secondary bit clock |
| frame_b_o | output | 1 | Secondary frame pulse, active low |
| oe_b_o | output | 1 | Secondary pair pad enable |
| sclk_o | output | 1 | Compatibility bit clock |
| sclkx2_o | output | 1 | Compatibility double-rate clock |
| fr_comp_o | output | 1 | Compatibility framing pulse |
| oe_comp_o | output | 1 | Compatibility group pad enable |

## Verification
The hardest case to reach is a write arriving mid-frame while an earlier setting is still applied. In that window the outputs must keep the old shape until the boundary and then switch cleanly. The bench therefore issues every write at mid-frame and checks every reference cycle on both sides of the boundary. It sweeps all legal rate, width, placement and polarity combinations, with varying invert and enable bits. It then writes reserved codes mixed with legal field changes, to show that only the offending field is held.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  localparam int CFG_W = 12;
  localparam logic [1:0] CODE_RSVD = 2'b11;

  localparam logic [1:0] FR_STRADDLE = 2'd0;
  localparam logic [1:0] FR_LAST     = 2'd1;
  localparam logic [1:0] FR_FIRST    = 2'd2;

  typedef struct packed {
    logic [1:0] sclk_rate;   // 11:10
    logic       sclkx2_inv;  // 9
    logic       sclk_inv;    // 8
    logic [1:0] fr_width;    // 7:6
    logic [1:0] fr_type;     // 5:4
    logic       fr_pol;      // 3
    logic       oe_comp;     // 2
    logic       oe_b;        // 1
    logic       oe_a;        // 0
  } tbus_cfg_t;
endpackage

// File: rtl/tbus_frame_timer.sv
module tbus_frame_timer #(
  parameter int FRAME_CYC = 4096,
  localparam int CNT_W = $clog2(FRAME_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_end_o
);
  logic [CNT_W-1:0] cnt_q;

  assign frame_end_o = (cnt_q == CNT_W'(FRAME_CYC - 1));
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (frame_end_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < FRAME_CYC);
  assert_cnt_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (cnt_q == '0));
endmodule

// File: rtl/tbus_cfg_reg.sv
module tbus_cfg_reg
  import tbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             load_i,
  output tbus_cfg_t        act_o,
  output logic             err_o
);
  tbus_cfg_t shadow_q, act_q, wr_cfg, nxt_cfg;
  logic      err_q, rsvd_hit;

  always_comb begin
    wr_cfg   = tbus_cfg_t'(wdata_i);
    nxt_cfg  = wr_cfg;
    rsvd_hit = 1'b0;
    if (wr_cfg.sclk_rate == CODE_RSVD) begin
      nxt_cfg.sclk_rate = shadow_q.sclk_rate;
      rsvd_hit = 1'b1;
    end
    if (wr_cfg.fr_width == CODE_RSVD) begin
      nxt_cfg.fr_width = shadow_q.fr_width;
      rsvd_hit = 1'b1;
    end
    if (wr_cfg.fr_type == CODE_RSVD) begin
      nxt_cfg.fr_type = shadow_q.fr_type;
      rsvd_hit = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      if (we_i) shadow_q <= nxt_cfg;
      if (we_i && rsvd_hit) err_q <= 1'b1;
      // staged settings reach the outputs only at the frame boundary
      if (load_i) act_q <= shadow_q;
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

  assert_hold_type_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[5:4] == CODE_RSVD) |=> (shadow_q.fr_type == $past(shadow_q.fr_type)));
  assert_hold_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[7:6] == CODE_RSVD) |=> (shadow_q.fr_width == $past(shadow_q.fr_width)));
  assert_err_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[11:10] == CODE_RSVD) |=> err_q);
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_apply_at_boundary_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/tbus_clk_shaper.sv
module tbus_clk_shaper
  import tbus_pkg::*;
#(
  parameter int FRAME_CYC = 4096,
  localparam int CNT_W = $clog2(FRAME_CYC),
  localparam int N_PAIR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  tbus_cfg_t         cfg_i,
  output logic [N_PAIR-1:0] pair_clk_o,
  output logic [N_PAIR-1:0] pair_frm_o,
  output logic [N_PAIR-1:0] pair_oe_o,
  output logic              sclk_o,
  output logic              sclkx2_o,
  output logic              fr_comp_o,
  output logic              oe_comp_o
);
  logic [1:0]  sclk_bit, x2_bit;
  logic [2:0]  wid_log;
  logic [31:0] pos_w, per_w, half_w;
  logic        c8_nxt, frm_nxt, sclk_nxt, x2_nxt, fr_act, fr_nxt;

  always_comb begin
    pos_w    = 32'(cnt_i);
    c8_nxt   = ~cnt_i[1];
    frm_nxt  = ~((pos_w >= 32'(FRAME_CYC - 2)) || (pos_w < 32'd2));
    // rate code 0/1/2 -> half-period 8/4/2 cycles -> counter bit 3/2/1
    sclk_bit = 2'd3 - cfg_i.sclk_rate;
    x2_bit   = sclk_bit - 2'd1;
    sclk_nxt = ~cnt_i[sclk_bit] ^ cfg_i.sclk_inv;
    x2_nxt   = ~cnt_i[x2_bit] ^ cfg_i.sclkx2_inv;
    wid_log  = 3'd4 - {1'b0, cfg_i.fr_width};
    per_w    = 32'd1 << wid_log;
    half_w   = per_w >> 1;
    case (cfg_i.fr_type)
      FR_STRADDLE: fr_act = (pos_w >= 32'(FRAME_CYC) - half_w) || (pos_w < half_w);
      FR_LAST:     fr_act = (pos_w >= 32'(FRAME_CYC) - per_w);
      FR_FIRST:    fr_act = (pos_w < per_w);
      default:     fr_act = 1'b0;
    endcase
    fr_nxt = fr_act ? cfg_i.fr_pol : ~cfg_i.fr_pol;
  end

  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    logic clk_q, frm_q, oe_q, oe_sel;
    assign oe_sel = (g == 0) ? cfg_i.oe_a : cfg_i.oe_b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        clk_q <= 1'b0;
        frm_q <= 1'b1;
        oe_q  <= 1'b0;
      end else begin
        clk_q <= c8_nxt;
        frm_q <= frm_nxt;
        oe_q  <= oe_sel;
      end
    end
    assign pair_clk_o[g] = clk_q;
    assign pair_frm_o[g] = frm_q;
    assign pair_oe_o[g]  = oe_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o    <= 1'b0;
      sclkx2_o  <= 1'b0;
      fr_comp_o <= 1'b1;
      oe_comp_o <= 1'b0;
    end else begin
      sclk_o    <= sclk_nxt;
      sclkx2_o  <= x2_nxt;
      fr_comp_o <= fr_nxt;
      oe_comp_o <= cfg_i.oe_comp;
    end
  end

  assert_c8_start_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> pair_clk_o[0]);
  assert_frame_low_at_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> !pair_frm_o[1]);
  assert_sclk_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> (sclk_o != $past(cfg_i.sclk_inv)));
  assert_x2_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> (sclkx2_o != $past(cfg_i.sclkx2_inv)));
  assert_fr_idle_midframe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(FRAME_CYC / 2)) |=> (fr_comp_o != $past(cfg_i.fr_pol)));
endmodule

// File: rtl/tbus_clk_gen.sv
module tbus_clk_gen
  import tbus_pkg::*;
#(
  parameter int FRAME_CYC = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             cfg_err_o,
  output logic             c8_a_o,
  output logic             frame_a_o,
  output logic             oe_a_o,
  output logic             c8_b_o,
  output logic             frame_b_o,
  output logic             oe_b_o,
  output logic             sclk_o,
  output logic             sclkx2_o,
  output logic             fr_comp_o,
  output logic             oe_comp_o
);
  localparam int CNT_W = $clog2(FRAME_CYC);

  logic [CNT_W-1:0] cnt;
  logic             frame_end;
  tbus_cfg_t        act_cfg;
  logic [1:0]       pair_clk, pair_frm, pair_oe;

  tbus_frame_timer #(.FRAME_CYC(FRAME_CYC)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_o       (cnt),
    .frame_end_o (frame_end)
  );

  tbus_cfg_reg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .load_i  (frame_end),
    .act_o   (act_cfg),
    .err_o   (cfg_err_o)
  );

  tbus_clk_shaper #(.FRAME_CYC(FRAME_CYC)) i_shaper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .cfg_i      (act_cfg),
    .pair_clk_o (pair_clk),
    .pair_frm_o (pair_frm),
    .pair_oe_o  (pair_oe),
    .sclk_o     (sclk_o),
    .sclkx2_o   (sclkx2_o),
    .fr_comp_o  (fr_comp_o),
    .oe_comp_o  (oe_comp_o)
  );

  assign c8_a_o    = pair_clk[0];
  assign frame_a_o = pair_frm[0];
  assign oe_a_o    = pair_oe[0];
  assign c8_b_o    = pair_clk[1];
  assign frame_b_o = pair_frm[1];
  assign oe_b_o    = pair_oe[1];
endmodule

// File: tb/test_tbus_clk_gen.sv
`timescale 1ns/1ps
module test_tbus_clk_gen;
  localparam int F = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, we;
  logic [11:0] wdata;
  logic err, c8a, fra, oea, c8b, frb, oeb, sclk, x2, frc, oec;

  tbus_clk_gen #(.FRAME_CYC(F)) i_tbus_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_err_o(err), .c8_a_o(c8a), .frame_a_o(fra), .oe_a_o(oea),
    .c8_b_o(c8b), .frame_b_o(frb), .oe_b_o(oeb), .sclk_o(sclk),
    .sclkx2_o(x2), .fr_comp_o(frc), .oe_comp_o(oec)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, run_chk = 0, mdl_ok = 0;
  int m_cnt = 0, e_pos = 0;
  logic [11:0] sh = '0, act = '0, oact = '0;
  bit e_err = 0;

  // R1 field map: [0] oe A, [1] oe B, [2] oe comp, [3] pol, [5:4] place, [7:6] width, [8] sclk inv, [9] x2 inv, [11:10] rate
  function automatic logic [11:0] merge(logic [11:0] old, logic [11:0] w);
    logic [11:0] r = w;
    if (w[5:4] == 2'b11)   r[5:4]   = old[5:4];
    if (w[7:6] == 2'b11)   r[7:6]   = old[7:6];
    if (w[11:10] == 2'b11) r[11:10] = old[11:10];
    return r;
  endfunction

  function automatic bit lvl(int p, int half);
    return ((p / half) % 2) == 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; mdl_ok <= 0; sh <= '0; act <= '0; oact <= '0; e_err <= 0; e_pos <= 0;
    end else begin
      mdl_ok <= 1;
      e_pos  <= m_cnt;
      m_cnt  <= (m_cnt + 1) % F;
      oact   <= act;
      if (m_cnt == F - 1) act <= sh;
      if (we) begin
        sh <= merge(sh, wdata);
        if (wdata[5:4] == 2'b11 || wdata[7:6] == 2'b11 || wdata[11:10] == 2'b11) e_err <= 1;
      end
    end
  end

  task automatic chk(logic got, logic exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at frame position %0d", tag, got, exp, e_pos);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk && mdl_ok) begin
      int half_s, per, p;
      bit act_w, e_sclk, e_x2;
      p      = e_pos;
      half_s = 8 >> oact[11:10];
      per    = 16 >> oact[7:6];
      e_sclk = lvl(p, half_s) ^ oact[8];
      e_x2   = lvl(p, half_s / 2) ^ oact[9];
      case (oact[5:4])
        2'd0:    act_w = (p >= F - per / 2) || (p < per / 2);
        2'd1:    act_w = (p >= F - per);
        default: act_w = (p < per);
      endcase
      chk(c8a, lvl(p, 2), "R3 c8_a");
      chk(c8b, lvl(p, 2), "R3 c8_b");
      chk(fra, !((p >= F - 2) || (p < 2)), "R3 frame_a");
      chk(frb, !((p >= F - 2) || (p < 2)), "R3 frame_b");
      chk(sclk, e_sclk, "R4/R6 sclk");
      chk(x2, e_x2, "R5/R6 sclkx2");
      chk(frc, act_w ? oact[3] : !oact[3], "R7/R8/R9 fr_comp");
      chk(oea, oact[0], "R11 oe_a");
      chk(oeb, oact[1], "R11 oe_b");
      chk(oec, oact[2], "R11 oe_comp");
      chk(err, e_err, "R10 cfg_err");
      if (oact != sh) chk(oea ^ oeb ^ oec, ^oact[2:0], "R12 deferred enables");
    end
  end

  task automatic wait_pos(int p);
    do @(negedge clk); while (e_pos != p || !mdl_ok);
  endtask

  task automatic write_cfg(logic [11:0] v);
    wait_pos(F / 2);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
    wait_pos(F / 2);
  endtask

  task automatic reset_checks();
    chk(oea, 1'b0, "R2 oe_a"); chk(oeb, 1'b0, "R2 oe_b"); chk(oec, 1'b0, "R2 oe_comp");
    chk(c8a, 1'b0, "R2 c8_a"); chk(c8b, 1'b0, "R2 c8_b");
    chk(fra, 1'b1, "R2 frame_a"); chk(frb, 1'b1, "R2 frame_b");
    chk(sclk, 1'b0, "R2 sclk"); chk(x2, 1'b0, "R2 sclkx2");
    chk(frc, 1'b1, "R2 fr_comp"); chk(err, 1'b0, "R2 cfg_err");
  endtask

  initial begin
    int idx = 0;
    rst_n = 1'b0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    run_chk = 1;
    @(negedge clk);
    chk(c8a, 1'b1, "R2 first edge frame start");
    chk(fra, 1'b0, "R2 first edge frame pulse");
    for (int r = 0; r < 3; r++)
      for (int w = 0; w < 3; w++)
        for (int t = 0; t < 3; t++)
          for (int p = 0; p < 2; p++) begin
            logic [11:0] v;
            v = {r[1:0], 1'(w ^ r), 1'(t ^ p), w[1:0], t[1:0], 1'(p), 3'(idx)};
            write_cfg(v);
            idx++;
          end
    chk(err, 1'b0, "R10 no error after legal writes");
    // R10: reserved codes alongside legal changes
    write_cfg({2'd1, 1'b0, 1'b1, 2'd2, 2'b11, 1'b1, 3'b101});
    chk(err, 1'b1, "R10 error after reserved placement");
    write_cfg({2'b11, 1'b1, 1'b0, 2'b11, 2'd1, 1'b0, 3'b011});
    write_cfg({2'd2, 1'b0, 1'b0, 2'd0, 2'd2, 1'b1, 3'b110});
    chk(err, 1'b1, "R10 error sticky after legal write");
    run_chk = 0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule